// File: doc/BRIEF.md
# Nibble ALU with Status and Carry Flags

This block is the arithmetic and compare core of a small 4-bit microcontroller datapath. Each cycle it takes a decoded operation code, two operand nibbles (the sequencer feeds it accumulator, B register, memory nibble or immediate as the instruction needs), and a bit index. It returns a result nibble together with the next value of a single status flip-flop and of a carry flip-flop. Both flip-flops live inside the block.

The status flag is what a following conditional branch tests. Its source depends on the operation: the carry-out for additions, the no-borrow condition for subtractions, not-zero for increment and decrement, the compare outcome for compares, and a selected memory bit for bit tests. Every other operation drives it to 1, so an unconditional branch that follows is always taken. The carry flip-flop is written by exactly eight operations and holds its value through every other one.

Top module: `nib_alu`

## Requirements
- R1: Operation code 0 (add) gives result (opa+opb) mod 16 and status = carry-out, and does not write carry. Operation code 1 (add with carry) gives (opa+opb+carry) mod 16, and both status and carry take the carry-out.
- R2: Operation code 2 (subtract) gives (opa-opb) mod 16 and status = 1 when opa >= opb (no borrow), and does not write carry. Operation code 3 (subtract with carry, where carry 1 means no borrow in) gives (opa-opb-(1-carry)) mod 16, and both status and carry take the no-borrow condition.
- R3: Operation code 15 (increment, opa+1) and operation code 16 (decrement, opa-1) give the result mod 16, with status = 1 exactly when that result is not zero.
- R4: Operation code 10 sets status when opa differs from opb. Operation code 11 sets status when opa <= opb as unsigned nibbles. Both return opa as the result.
- R5: Operation code 12 returns opa with bit bidx forced to 1, operation code 13 returns opa with bit bidx forced to 0, and operation code 14 returns opa with status = opa[bidx].
- R6: Operation code 6 (rotate left) returns {opa[2:0],carry} and writes opa[3] to carry. Operation code 7 (rotate right) returns {carry,opa[3:1]} and writes opa[0] to carry.
- R7: Operation code 8 (decimal adjust after add) adds 6 mod 16 when opa > 9 or carry is set, and writes carry = (opa > 9 or carry). Operation code 9 (decimal adjust after subtract) subtracts 6 mod 16 when carry is clear, and writes carry unchanged.
- R8: Operation code 4 writes carry = 1 and operation code 5 writes carry = 0. Both return opa with status 1.
- R9: Operation code 17 returns opb with status 1. Every unlisted code (18 to 31) returns opa with status 1 and writes no carry.
- R10: carry_we is 1 only for operation codes 1, 3, 4, 5, 6, 7, 8 and 9 with exec high. For every other operation the carry flip-flop keeps its value.
- R11: The flag flip-flops load stat_next and carry_next on a rising clock edge only when their write enable is high. stat_we equals exec. A synchronous reset clears both flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec | input | 1 | Operation executes this cycle and may update the flags |
| op | input | 5 | Decoded operation code |
| opa | input | W | First operand nibble |
| opb | input | W | Second operand nibble |
| bidx | input | log2(W) | Bit index for the bit operations |
| result | output | W | Result nibble |
| stat_next | output | 1 | Status value that the current operation produces |
| carry_next | output | 1 | Carry value that the current operation produces |
| stat_we | output | 1 | Status flip-flop write enable |
| carry_we | output | 1 | Carry flip-flop write enable |
| stat_q | output | 1 | Status flip-flop |
| carry_q | output | 1 | Carry flip-flop |

## Verification
The bench builds the block with its default width W = 4. At this width all 32 operation codes, every operand pair and both carry states can be swept exhaustively, and the bit operations can be swept over all four indices. Each vector first loads the carry through the set and reset carry operations. It then checks the combinational outputs and, one edge later, the flags, which brings the carry-hold rule and the decimal-adjust boundaries at 9 and 10 fully within reach. A further pass per operation holds exec low and shows that the flags keep their values.

// File: rtl/nib_alu.sv
module nib_alu #(
  parameter int W = 4,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec,
  input  logic [4:0]    op,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [IW-1:0] bidx,
  output logic [W-1:0]  result,
  output logic          stat_next,
  output logic          carry_next,
  output logic          stat_we,
  output logic          carry_we,
  output logic          stat_q,
  output logic          carry_q
);
  localparam logic [4:0] OP_ADD = 5'd0, OP_ADDC = 5'd1, OP_SUB = 5'd2, OP_SUBC = 5'd3,
                         OP_SETC = 5'd4, OP_RESC = 5'd5, OP_ROTL = 5'd6, OP_ROTR = 5'd7,
                         OP_DAA = 5'd8, OP_DAS = 5'd9, OP_NE = 5'd10, OP_LE = 5'd11,
                         OP_BSET = 5'd12, OP_BRES = 5'd13, OP_BTST = 5'd14,
                         OP_INC = 5'd15, OP_DEC = 5'd16, OP_XFER = 5'd17;
  localparam logic [W-1:0] NINE = W'(9);
  localparam logic [W-1:0] SIX  = W'(6);
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W:0]   sum, diff;
  logic [W-1:0] bmask;
  logic         cw_op;

  assign sum   = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, (op == OP_ADDC) & carry_q};
  assign diff  = {1'b0, opa} + {1'b0, ~opb} + {{W{1'b0}}, (op == OP_SUBC) ? carry_q : 1'b1};
  assign bmask = ONE << bidx;

  always_comb begin
    result     = opa;
    stat_next  = 1'b1;
    carry_next = carry_q;
    cw_op      = 1'b0;
    case (op)
      OP_ADD:  begin result = sum[W-1:0]; stat_next = sum[W]; end
      OP_ADDC: begin result = sum[W-1:0]; stat_next = sum[W]; carry_next = sum[W]; cw_op = 1'b1; end
      OP_SUB:  begin result = diff[W-1:0]; stat_next = diff[W]; end
      OP_SUBC: begin result = diff[W-1:0]; stat_next = diff[W]; carry_next = diff[W]; cw_op = 1'b1; end
      OP_SETC: begin carry_next = 1'b1; cw_op = 1'b1; end
      OP_RESC: begin carry_next = 1'b0; cw_op = 1'b1; end
      OP_ROTL: begin result = {opa[W-2:0], carry_q}; carry_next = opa[W-1]; cw_op = 1'b1; end
      OP_ROTR: begin result = {carry_q, opa[W-1:1]}; carry_next = opa[0]; cw_op = 1'b1; end
      OP_DAA: begin
        cw_op = 1'b1;
        if (opa > NINE || carry_q) begin
          result     = opa + SIX;
          carry_next = 1'b1;
        end
      end
      OP_DAS: begin
        cw_op = 1'b1;
        if (!carry_q) result = opa - SIX;
      end
      OP_NE:   stat_next = (opa != opb);
      OP_LE:   stat_next = (opa <= opb);
      OP_BSET: result = opa | bmask;
      OP_BRES: result = opa & ~bmask;
      OP_BTST: stat_next = |(opa & bmask);
      OP_INC:  begin result = opa + ONE; stat_next = |result; end
      OP_DEC:  begin result = opa - ONE; stat_next = |result; end
      OP_XFER: result = opb;
      default: ;
    endcase
  end

  assign stat_we  = exec;
  assign carry_we = exec & cw_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      if (stat_we)  stat_q  <= stat_next;
      if (carry_we) carry_q <= carry_next;
    end
  end

  // R11
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!stat_q && !carry_q));
  // R11
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst) !stat_we |=> $stable(stat_q));
  // R11
  stat_load_chk: assert property (@(posedge clk) disable iff (rst) stat_we |=> (stat_q == $past(stat_next)));
  // R10
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst) !carry_we |=> $stable(carry_q));
  // R10
  carry_load_chk: assert property (@(posedge clk) disable iff (rst) carry_we |=> (carry_q == $past(carry_next)));
  // R10
  carry_we_exec_chk: assert property (@(posedge clk) disable iff (rst) carry_we |-> stat_we);
endmodule

// File: tb/sim_nib_alu.sv
module sim_nib_alu;
  localparam int CLK_P = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exec = 1'b0;
  logic [4:0] op = '0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [1:0] bidx = '0;
  logic [W-1:0] result;
  logic stat_next, carry_next, stat_we, carry_we, stat_q, carry_q;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  nib_alu #(.W(W)) u0 (
    .clk(clk), .rst(rst), .exec(exec), .op(op), .opa(opa), .opb(opb), .bidx(bidx),
    .result(result), .stat_next(stat_next), .carry_next(carry_next),
    .stat_we(stat_we), .carry_we(carry_we), .stat_q(stat_q), .carry_q(carry_q)
  );

  logic [3:0] e_r;
  logic e_s, e_c, e_cw;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s op=%0d a=%0d b=%0d n=%0d: actual %0d expected %0d",
               req, what, op, opa, opb, bidx, act, exp);
    end
  endtask

  function automatic string req_of(input int o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      15, 16: return "R3";
      10, 11: return "R4";
      12, 13, 14: return "R5";
      6, 7: return "R6";
      8, 9: return "R7";
      4, 5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic model(input int o, input int a, input int b, input int n, input int c);
    int t;
    e_r = 4'(a); e_s = 1'b1; e_c = 1'(c); e_cw = 1'b0;
    case (o)
      0: begin t = a + b; e_r = 4'(t); e_s = (t > 15); end
      1: begin t = a + b + c; e_r = 4'(t); e_s = (t > 15); e_c = e_s; e_cw = 1; end
      2: begin e_r = 4'(a - b + 16); e_s = (a >= b); end
      3: begin e_r = 4'(a - b - (1 - c) + 32); e_s = (a >= b + (1 - c)); e_c = e_s; e_cw = 1; end
      4: begin e_c = 1; e_cw = 1; end
      5: begin e_c = 0; e_cw = 1; end
      6: begin e_r = 4'((a * 2) % 16 + c); e_c = 1'((a / 8) % 2); e_cw = 1; end
      7: begin e_r = 4'(c * 8 + a / 2); e_c = 1'(a % 2); e_cw = 1; end
      8: begin e_cw = 1; if (a > 9 || c == 1) begin e_r = 4'(a + 6); e_c = 1; end end
      9: begin e_cw = 1; if (c == 0) e_r = 4'(a + 10); end
      10: e_s = (a != b);
      11: e_s = (a <= b);
      12: e_r = 4'(a | (1 << n));
      13: e_r = 4'(a & ~(1 << n));
      14: e_s = 1'((a >> n) % 2);
      15: begin e_r = 4'(a + 1); e_s = (e_r != 0); end
      16: begin e_r = 4'(a + 15); e_s = (e_r != 0); end
      17: e_r = 4'(b);
      default: ;
    endcase
  endtask

  task automatic run_vec(input int o, input int a, input int b, input int n, input int c, input bit ex);
    string rq;
    @(negedge clk);
    op = (c == 1) ? 5'd4 : 5'd5; exec = 1'b1;
    @(negedge clk);
    chk("R8", "preset carry", carry_q, c);
    op = 5'(o); opa = 4'(a); opb = 4'(b); bidx = 2'(n); exec = ex;
    model(o, a, b, n, c);
    rq = req_of(o);
    #1;
    chk(rq, "result", result, e_r);
    chk(rq, "stat_next", stat_next, e_s);
    if (e_cw) chk(rq, "carry_next", carry_next, e_c);
    chk("R10", "carry_we", carry_we, e_cw & ex);
    chk("R11", "stat_we", stat_we, ex);
    @(posedge clk); #1;
    if (ex) begin
      chk(rq, "stat_q", stat_q, e_s);
      chk("R10", "carry_q", carry_q, e_cw ? e_c : 1'(c));
    end else begin
      chk("R11", "stat_q held", stat_q, 1);
      chk("R11", "carry_q held", carry_q, c);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    exec = 1'b1; op = 5'd4;
    @(negedge clk);
    #1;
    chk("R11", "stat_q in reset", stat_q, 0);
    chk("R11", "carry_q in reset", carry_q, 0);
    rst = 1'b0;
    for (int o = 0; o < 32; o++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++) begin
          if (o >= 12 && o <= 14) begin
            for (int n = 0; n < 4; n++) run_vec(o, a, 0, n, c, 1'b1);
          end else begin
            for (int b = 0; b < 16; b++) run_vec(o, a, b, 0, c, 1'b1);
          end
        end
    for (int o = 0; o < 32; o++)
      for (int c = 0; c < 2; c++) begin
        run_vec(o, 3, 12, 1, c, 1'b0);
        run_vec(o, 12, 3, 2, c, 1'b0);
      end
    @(negedge clk);
    rst = 1'b1; exec = 1'b0;
    @(posedge clk); #1;
    chk("R11", "stat_q after reset", stat_q, 0);
    chk("R11", "carry_q after reset", carry_q, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule